// File: doc/BRIEF.md
# LED Matrix Scan Engine

This block multiplexes a row/column LED matrix. Time is cut into slots. In each slot exactly one row is driven, together with up to `GROUP` column pins of that row. Each column pin carries a pulse whose width follows the 8-bit brightness of the pixel shown on it.

Pixels are numbered linearly and stored in an external frame buffer. The block reads that buffer through a combinational read port. A byte-per-pixel mapping table gives each pixel's place in the matrix. When `GROUP` is above 1, the block walks the matrix in row-major position order and looks up which pixel, if any, sits at each position. When `GROUP` is 1, it walks pixel indices directly.

Every row and column pin has its own polarity flag. A blank input turns the whole display dark, and releasing it restarts the scan from the beginning.

Top module: `ledmx_scanner`

## Requirements
- R1: Each mapping byte holds the pixel's row index in bits 7:4 and its column index in bits 3:0. Every entry must name a row below `ROWS` and a column below `COLS`.
- R2: With `GROUP` > 1, positions are visited in the order row*COLS+column, wrapping to 0 after the last one. A position that no pixel maps to is skipped, and each skip costs one load cycle.
- R3: A group collects consecutive mapped pixels, up to `GROUP` of them. It ends early when the next mapped pixel lies in a different row from the group's first pixel. That pixel then opens the following group.
- R4: A group's row is enabled for exactly 255*`QUANT` consecutive cycles, and at most one row is enabled at any time.
- R5: The column of each pixel in the group is active from the first cycle of the slot for brightness*`QUANT` cycles. Brightness 0 gives no pulse, and 255 keeps the column on for the whole slot.
- R6: Between slots, all rows and columns are inactive for one cycle per position examined by the load step: skipped positions, plus accepted pixels, plus one more when the group ended on a row change. The row and its columns then switch on in the same cycle.
- R7: Each output pin equals its logical value XOR its polarity flag, so the inactive level of a pin equals its flag.
- R8: From the cycle after `blank_i` is sampled high, and for as long as it stays high, every row and column sits at its inactive level.
- R9: After `blank_i` is sampled low, scanning restarts at position 0 with a cleared slot timer. The first row is enabled after the same gap that R6 gives for that first group.
- R10: During and after reset all outputs are inactive. The first group then follows the R9 timing, counted from the first clock edge after reset with `blank_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blank_i | input | 1 | Blank request; high darkens the display and stops scanning |
| map_i | input | NPIX*8 | Mapping table; byte i places pixel i (row in bits 7:4, column in bits 3:0) |
| row_pol_i | input | ROWS | Per-row polarity flag, 1 = active low |
| col_pol_i | input | COLS | Per-column polarity flag, 1 = active low |
| fb_data_i | input | 8 | Brightness of the pixel at `fb_addr_o`, same cycle |
| fb_addr_o | output | PIXW | Frame-buffer read address (pixel index) |
| row_o | output | ROWS | Row drive pins |
| col_o | output | COLS | Column drive pins |

## Verification
Each load cycle is one clock edge, so the dark gap before a slot lasts exactly as many sampled cycles as the bench's position walk predicts. The bench counts dark samples until a row appears and compares that count with its own model. Once the row is on, the bench samples every cycle of the 255*`QUANT`-cycle slot at the falling edge. Column k of the slot is expected at sample j exactly when j < brightness*`QUANT`. A blank request must show at the first falling-edge sample after the edge that captured it, and a release must reproduce the first group's gap counted from that edge.

// File: rtl/lms_pkg.sv
package lms_pkg;
    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_LOAD  = 2'd1,
        ST_LIGHT = 2'd2
    } scan_st_e;
endpackage

// File: rtl/lms_order.sv
module lms_order #(
    parameter int ROWS  = 3,
    parameter int COLS  = 4,
    parameter int NPIX  = 10,
    parameter int GROUP = 3,
    parameter int POSW  = 4,
    parameter int PIXW  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPIX*8-1:0] map_i,
    input  logic [POSW-1:0]   pos_i,
    output logic              hit_o,
    output logic [PIXW-1:0]   pix_o,
    output logic [3:0]        row_o,
    output logic [3:0]        col_o
);
    logic [7:0] entry [NPIX];
    logic [7:0] sel;

    for (genvar g = 0; g < NPIX; g++) begin : g_unpack
        assign entry[g] = map_i[g*8 +: 8];
        // R1
        map_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (int'(entry[g][7:4]) < ROWS) && (int'(entry[g][3:0]) < COLS));
    end

    if (GROUP > 1) begin : g_matrix_order
        always_comb begin
            hit_o = 1'b0;
            pix_o = '0;
            for (int i = 0; i < NPIX; i++) begin
                if (int'(entry[i][7:4]) * COLS + int'(entry[i][3:0]) == int'(pos_i)) begin
                    hit_o = 1'b1;
                    pix_o = PIXW'(i);
                end
            end
        end
    end else begin : g_index_order
        assign hit_o = 1'b1;
        assign pix_o = PIXW'(pos_i);
    end

    assign sel   = entry[pix_o];
    assign row_o = sel[7:4];
    assign col_o = sel[3:0];
endmodule

// File: rtl/lms_pol.sv
module lms_pol #(
    parameter int W = 4
) (
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] pin_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pin_o[b] = lvl_i[b] ^ pol_i[b];
    end
endmodule

// File: rtl/ledmx_scanner.sv
module ledmx_scanner #(
    parameter int ROWS  = 3,
    parameter int COLS  = 4,
    parameter int NPIX  = 10,
    parameter int GROUP = 3,
    parameter int QUANT = 2,
    localparam int PIXW = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              blank_i,
    input  logic [NPIX*8-1:0] map_i,
    input  logic [ROWS-1:0]   row_pol_i,
    input  logic [COLS-1:0]   col_pol_i,
    input  logic [7:0]        fb_data_i,
    output logic [PIXW-1:0]   fb_addr_o,
    output logic [ROWS-1:0]   row_o,
    output logic [COLS-1:0]   col_o
);
    import lms_pkg::*;

    localparam int NPOS = (GROUP > 1) ? ROWS * COLS : NPIX;
    localparam int POSW = (NPOS > 1) ? $clog2(NPOS) : 1;
    localparam int SLOT = 255 * QUANT;
    localparam int TW   = $clog2(SLOT);
    localparam int CW   = $clog2(GROUP + 1);

    typedef struct packed {
        scan_st_e                st;
        logic [POSW-1:0]         pos;
        logic [CW-1:0]           cnt;
        logic [3:0]              row;
        logic [GROUP-1:0][3:0]   ch_col;
        logic [GROUP-1:0][7:0]   ch_bri;
        logic [TW-1:0]           tick;
        logic [ROWS-1:0]         row_lo;
        logic [COLS-1:0]         col_lo;
    } scan_s;

    scan_s q, d;

    logic            hit;
    logic [PIXW-1:0] pix;
    logic [3:0]      m_row;
    logic [3:0]      m_col;

    lms_order #(
        .ROWS (ROWS),
        .COLS (COLS),
        .NPIX (NPIX),
        .GROUP(GROUP),
        .POSW (POSW),
        .PIXW (PIXW)
    ) i_order (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .map_i (map_i),
        .pos_i (q.pos),
        .hit_o (hit),
        .pix_o (pix),
        .row_o (m_row),
        .col_o (m_col)
    );

    assign fb_addr_o = pix;

    function automatic logic [POSW-1:0] step_pos(logic [POSW-1:0] p);
        return (int'(p) == NPOS - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        case (q.st)
            ST_BLANK: begin
                d.st   = ST_LOAD;
                d.pos  = '0;
                d.cnt  = '0;
                d.tick = '0;
            end
            ST_LOAD: begin
                if (!hit) begin
                    d.pos = step_pos(q.pos);
                end else if (q.cnt == '0 || m_row == q.row) begin
                    for (int i = 0; i < GROUP; i++) begin
                        if (CW'(i) == q.cnt) begin
                            d.ch_col[i] = m_col;
                            d.ch_bri[i] = fb_data_i;
                        end
                    end
                    if (q.cnt == '0) begin
                        d.row = m_row;
                    end
                    d.cnt = q.cnt + 1'b1;
                    d.pos = step_pos(q.pos);
                    if (int'(q.cnt) == GROUP - 1) begin
                        d.st   = ST_LIGHT;
                        d.tick = '0;
                    end
                end else begin
                    d.st   = ST_LIGHT;
                    d.tick = '0;
                end
            end
            ST_LIGHT: begin
                if (int'(q.tick) == SLOT - 1) begin
                    d.st  = ST_LOAD;
                    d.cnt = '0;
                end else begin
                    d.tick = q.tick + 1'b1;
                end
            end
            default: d.st = ST_BLANK;
        endcase

        if (blank_i) begin
            d.st = ST_BLANK;
        end

        d.row_lo = '0;
        d.col_lo = '0;
        if (d.st == ST_LIGHT) begin
            for (int r = 0; r < ROWS; r++) begin
                if (4'(r) == d.row) begin
                    d.row_lo[r] = 1'b1;
                end
            end
            for (int i = 0; i < GROUP; i++) begin
                if (CW'(i) < d.cnt && int'(d.tick) < int'(d.ch_bri[i]) * QUANT) begin
                    for (int c = 0; c < COLS; c++) begin
                        if (4'(c) == d.ch_col[i]) begin
                            d.col_lo[c] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_BLANK, default: '0};
        end else begin
            q <= d;
        end
    end

    lms_pol #(.W(ROWS)) i_row_pol (
        .lvl_i(q.row_lo),
        .pol_i(row_pol_i),
        .pin_o(row_o)
    );

    lms_pol #(.W(COLS)) i_col_pol (
        .lvl_i(q.col_lo),
        .pol_i(col_pol_i),
        .pin_o(col_o)
    );

    // R4
    row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(q.row_lo));

    // R4
    row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_LIGHT && int'(q.tick) != SLOT - 1 && !blank_i) |=> $stable(q.row_lo));

    // R3
    grp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(q.cnt) <= GROUP);

    // R5
    col_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_LIGHT && q.tick != '0) |-> ((q.col_lo & ~$past(q.col_lo)) == '0));

    // R6
    col_needs_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|q.col_lo) |-> (|q.row_lo));

    // R6
    slot_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_LIGHT && int'(q.tick) == SLOT - 1) |=> (q.row_lo == '0 && q.col_lo == '0));

    // R8
    blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blank_i |=> (q.row_lo == '0 && q.col_lo == '0));
endmodule

// File: tb/test_ledmx_scanner.sv
module test_ledmx_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 3;
    localparam int COLS  = 4;
    localparam int NPIX  = 10;
    localparam int GROUP = 3;
    localparam int QUANT = 2;
    localparam int PIXW  = $clog2(NPIX);
    localparam int NPOS  = ROWS * COLS;
    localparam int SLOT  = 255 * QUANT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blank = 1'b0;
    logic [NPIX*8-1:0] map_flat;
    logic [7:0] map_b [NPIX];
    logic [7:0] fb [NPIX];
    logic [ROWS-1:0] row_pol = 3'b010;
    logic [COLS-1:0] col_pol = 4'b1001;
    logic [7:0] fb_data;
    logic [PIXW-1:0] fb_addr;
    logic [ROWS-1:0] row_o;
    logic [COLS-1:0] col_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fb_data = fb[fb_addr];

    ledmx_scanner #(
        .ROWS(ROWS), .COLS(COLS), .NPIX(NPIX), .GROUP(GROUP), .QUANT(QUANT)
    ) i_ledmx_scanner (
        .clk_i(clk), .rst_ni(rst_n), .blank_i(blank), .map_i(map_flat),
        .row_pol_i(row_pol), .col_pol_i(col_pol), .fb_data_i(fb_data),
        .fb_addr_o(fb_addr), .row_o(row_o), .col_o(col_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pix_at(int p);
        for (int i = 0; i < NPIX; i++) begin
            if (int'(map_b[i][7:4]) * COLS + int'(map_b[i][3:0]) == p) return i;
        end
        return -1;
    endfunction

    // Walks one group from cursor p, then checks gap, row and column pulses.
    task automatic slot(inout int p, input int cut, input string tag);
        int gap = 0;
        int grow = 0;
        int n = 0;
        int chc [GROUP];
        int chb [GROUP];
        int off = 0;
        int offbad = 0;
        int rowbad = 0;
        int colbad = 0;
        int fa = 0;
        int fe = 0;
        int len;
        logic [ROWS-1:0] exprow;
        logic [COLS-1:0] expcol;
        while (1) begin
            int px;
            gap++;
            px = pix_at(p);
            if (px < 0) begin
                p = (p + 1) % NPOS;
                continue;
            end
            if (n > 0 && int'(map_b[px][7:4]) != grow) break;
            if (n == 0) grow = int'(map_b[px][7:4]);
            chc[n] = int'(map_b[px][3:0]);
            chb[n] = int'(fb[px]);
            n++;
            p = (p + 1) % NPOS;
            if (n == GROUP) break;
        end
        while (row_o == row_pol && off < 3000) begin
            if (col_o != col_pol) offbad++;
            off++;
            @(negedge clk);
        end
        chk(off == gap, "R2 R3 R6", {tag, " dark gap cycles"}, off, gap);
        chk(offbad == 0, "R6", {tag, " columns dark in gap"}, offbad, 0);
        exprow = row_pol ^ (ROWS'(1) << grow);
        chk(row_o == exprow, "R1 R3", {tag, " row pins"}, int'(row_o), int'(exprow));
        len = (cut > 0) ? cut : SLOT;
        for (int j = 0; j < len; j++) begin
            expcol = '0;
            for (int k = 0; k < n; k++) begin
                if (j < chb[k] * QUANT) expcol[chc[k]] = 1'b1;
            end
            expcol = expcol ^ col_pol;
            if (col_o != expcol) begin
                if (colbad == 0) begin
                    fa = int'(col_o);
                    fe = int'(expcol);
                end
                colbad++;
            end
            if (row_o != exprow) rowbad++;
            @(negedge clk);
        end
        chk(colbad == 0, "R5 R7", {tag, " column pulse pattern"}, fa, fe);
        chk(rowbad == 0, "R4", {tag, " row held over slot"}, rowbad, 0);
        if (cut == 0) begin
            chk(row_o == row_pol, "R4", {tag, " row off after 255*QUANT cycles"},
                int'(row_o), int'(row_pol));
        end
    endtask

    initial begin
        int p;
        int bb;
        map_b = '{8'h23, 8'h00, 8'h12, 8'h03, 8'h10, 8'h21, 8'h11, 8'h01, 8'h22, 8'h13};
        fb    = '{8'd0, 8'd255, 8'd1, 8'd128, 8'd7, 8'd64, 8'd200, 8'd3, 8'd90, 8'd30};
        for (int i = 0; i < NPIX; i++) map_flat[i*8 +: 8] = map_b[i];

        repeat (3) @(negedge clk);
        chk(row_o == row_pol, "R10 R7", "rows during reset", int'(row_o), int'(row_pol));
        chk(col_o == col_pol, "R10 R7", "columns during reset", int'(col_o), int'(col_pol));
        rst_n = 1'b1;
        @(negedge clk);
        p = 0;
        for (int s = 0; s < 8; s++) slot(p, 0, "scan");

        slot(p, 100, "cut");
        blank = 1'b1;
        @(negedge clk);
        chk(row_o == row_pol && col_o == col_pol, "R8", "dark one cycle after blank",
            int'({row_o, col_o}), int'({row_pol, col_pol}));
        bb = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (row_o != row_pol || col_o != col_pol) bb++;
        end
        chk(bb == 0, "R8", "dark while blank held", bb, 0);
        blank = 1'b0;
        @(negedge clk);
        p = 0;
        for (int s = 0; s < 3; s++) slot(p, 0, "R9 restart");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule